// File: doc/BRIEF.md
# Five-Source Prioritized Interrupt Arbiter

This block collects interrupt requests from five sources, one external pin and four internal peripherals (time base, timer, counter, serial shifter), and hands the sequencer one accepted request at a time. Each source has a pending flag. A single global enable gates every acceptance. The first four sources also have their own enables. The serial source is gated by the global enable alone.

The external pin is active low. It passes through a two-flop synchronizer, and a falling edge is latched as a pending request. A separate inhibit input, which the sequencer drives while a port-bit reset operation runs, masks these edges. Internal sources raise their pending flags with one-cycle pulses. Software sets, clears and tests the flags through a small command port. Test commands return their answer combinationally on a single output bit, which the sequencer uses for its skip decision.

When the global enable is on, the sequencer allows acceptance and at least one pending source is enabled, the lowest-index source wins. The block then issues a one-cycle accept pulse with the source index. In the same step it clears the global enable and the winner's pending flag.

Top module: `irq_arbiter5`

## Requirements
- R1: After reset all pending flags, all per-source enables and the global enable are clear, and `irq_take` is low.
- R2: A high `src_req[k]` at a clock edge sets the pending flag of source k+1. Source indices are 0 external, 1 time base, 2 timer, 3 counter, 4 serial. The flag stays set for as long as the request cannot be accepted.
- R3: A falling edge on `ext_n` sets pending flag 0 at the third rising clock edge after `ext_n` goes low. A rising edge or a steady level sets nothing.
- R4: A falling edge of `ext_n` that is detected while `inh` is high is discarded, and pending flag 0 stays clear.
- R5: Command op 1 sets the global enable and op 2 clears it. While the global enable is clear, no request is accepted.
- R6: Op 3 sets and op 4 clears the enable of source `cmd_sel` (0..3). Op 6 returns that enable on `test_hit`. Source 4 has no enable: op 3 and op 4 are ignored for it, and op 6 returns 0.
- R7: Op 5 clears pending flag `cmd_sel`, and op 7 returns pending flag `cmd_sel` on `test_hit`. A new request in the same cycle wins over the clear.
- R8: When several eligible sources are pending, the lowest index is accepted first (0 highest priority, 4 lowest).
- R9: An acceptance gives exactly one cycle of `irq_take`, with `irq_src` holding the winner's index. It clears the global enable and the winner's pending flag. Flags of lower-priority sources stay pending.
- R10: While `take_ok` is low no acceptance happens. Acceptance follows on the edge after `take_ok` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_n | input | 1 | Asynchronous external interrupt pin, active low |
| inh | input | 1 | Inhibit window for external edges |
| src_req | input | 4 | Internal request pulses: time base, timer, counter, serial |
| take_ok | input | 1 | Sequencer can accept an interrupt now |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R5 to R7; 0 = none) |
| cmd_sel | input | 3 | Source index for the command |
| test_hit | output | 1 | Result of a test command, combinational |
| irq_take | output | 1 | One-cycle accept pulse |
| irq_src | output | 3 | Index of the accepted source |

## Verification
The hardest situation to reach is all five sources pending at once, with every acceptance checked against the priority order. A request is accepted the moment its enables allow it, so the bench first fills the flags with the global enable off. It drives an uninhibited external falling edge, then pulses all four internal requests, then enables every source. Only after that does it grant the global enable again for each acceptance, which lets the bench watch the sources drain in order 0, 1, 2, 3, 4 while the lower flags stay pending.

// File: rtl/irq_arbiter5.sv
module irq_arbiter5 #(
  parameter int NSRC = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ext_n,
  input  logic                     inh,
  input  logic [NSRC-2:0]          src_req,
  input  logic                     take_ok,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_op,
  input  logic [$clog2(NSRC)-1:0]  cmd_sel,
  output logic                     test_hit,
  output logic                     irq_take,
  output logic [$clog2(NSRC)-1:0]  irq_src
);
  localparam int SW = $clog2(NSRC);
  localparam logic [NSRC-1:0] ONE = NSRC'(1);
  localparam logic [2:0] OP_MSET = 3'd1, OP_MCLR = 3'd2, OP_ESET = 3'd3,
                         OP_ECLR = 3'd4, OP_PCLR = 3'd5, OP_ETST = 3'd6,
                         OP_PTST = 3'd7;

  logic [2:0]      sync;
  logic [NSRC-1:0] pend, en_full, elig, sel_oh, grant_oh, set_vec;
  logic [NSRC-2:0] en;
  logic            master, go, ext_fall;
  logic [SW-1:0]   win;

  assign ext_fall = sync[2] & ~sync[1];
  assign set_vec  = {src_req, ext_fall & ~inh};
  assign en_full  = {1'b1, en};
  assign elig     = pend & en_full & {NSRC{master}};
  assign go       = take_ok & (|elig);
  assign sel_oh   = cmd_valid ? (ONE << cmd_sel) : '0;
  assign grant_oh = go ? (ONE << win) : '0;

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (elig[i]) win = SW'(i);
  end

  assign test_hit = (cmd_op == OP_ETST) ? |(sel_oh & {1'b0, en}) :
                    (cmd_op == OP_PTST) ? |(sel_oh & pend) : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync     <= 3'b111;
      pend     <= '0;
      en       <= '0;
      master   <= 1'b0;
      irq_take <= 1'b0;
      irq_src  <= '0;
    end else begin
      sync <= {sync[1:0], ext_n};
      pend <= (pend & ~grant_oh & ~((cmd_op == OP_PCLR) ? sel_oh : '0)) | set_vec;
      if (cmd_op == OP_ESET) en <= en | sel_oh[NSRC-2:0];
      else if (cmd_op == OP_ECLR) en <= en & ~sel_oh[NSRC-2:0];
      if (go) master <= 1'b0;
      else if (cmd_valid && cmd_op == OP_MSET) master <= 1'b1;
      else if (cmd_valid && cmd_op == OP_MCLR) master <= 1'b0;
      irq_take <= go;
      if (go) irq_src <= win;
    end
  end

  a_r5_take_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(master));
  a_r9_master_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> !master);
  a_r9_winner_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (($past(pend) >> irq_src) & ONE) != '0);
  a_r8_no_higher_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> ($past(elig) & ((ONE << irq_src) - ONE)) == '0);
  a_r10_take_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> $past(take_ok));
  a_r4_inhibit_blocks_ext: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[0]) |-> !$past(inh));
endmodule

// File: tb/sim_irq_arbiter5.sv
module sim_irq_arbiter5;
  logic clk = 0, rst_n = 0, ext_n = 1, inh = 0, take_ok = 0, cmd_valid = 0;
  logic [3:0] src_req = '0;
  logic [2:0] cmd_op = '0, cmd_sel = '0;
  logic test_hit, irq_take;
  logic [2:0] irq_src;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_arbiter5 u0 (.clk, .rst_n, .ext_n, .inh, .src_req, .take_ok, .cmd_valid,
                   .cmd_op, .cmd_sel, .test_hit, .irq_take, .irq_src);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic cmd(input logic [2:0] op, input logic [2:0] sel);
    cmd_valid = 1; cmd_op = op; cmd_sel = sel;
    step();
    cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic probe(input logic [2:0] op, input logic [2:0] sel, output int v);
    cmd_valid = 1; cmd_op = op; cmd_sel = sel;
    #1 v = int'(test_hit);
    cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic t_reset();
    int v;
    for (int s = 0; s < 5; s++) begin
      probe(7, 3'(s), v); chk("R1 pending clear", v, 0);
      probe(6, 3'(s), v); chk("R1 enable clear", v, 0);
    end
    chk("R1 no take", int'(irq_take), 0);
  endtask

  task automatic t_internal();
    int v;
    cmd(3, 1);
    src_req = 4'b0001; step(); src_req = 0;
    probe(7, 1, v); chk("R2 time base pending", v, 1);
    repeat (5) step();
    probe(7, 1, v); chk("R2 held while master off", v, 1);
    chk("R5 no take with master clear", int'(irq_take), 0);
    cmd(5, 1);
    probe(7, 1, v); chk("R7 pending cleared", v, 0);
    src_req = 4'b0100; cmd_valid = 1; cmd_op = 5; cmd_sel = 3; step();
    cmd_valid = 0; cmd_op = 0; src_req = 0;
    probe(7, 3, v); chk("R7 set wins over clear", v, 1);
    cmd(5, 3);
    cmd(4, 1);
  endtask

  task automatic t_enable();
    int v;
    cmd(3, 2); probe(6, 2, v); chk("R6 enable set", v, 1);
    cmd(4, 2); probe(6, 2, v); chk("R6 enable clear", v, 0);
    cmd(3, 4); probe(6, 4, v); chk("R6 serial has no enable", v, 0);
  endtask

  task automatic t_ext();
    int v;
    ext_n = 0;
    step(); step();
    probe(7, 0, v); chk("R3 not yet after two edges", v, 0);
    step();
    probe(7, 0, v); chk("R3 set on third edge", v, 1);
    cmd(5, 0);
    ext_n = 1; repeat (4) step();
    probe(7, 0, v); chk("R3 rising edge sets nothing", v, 0);
  endtask

  task automatic t_inhibit();
    int v;
    inh = 1; ext_n = 0; repeat (6) step();
    inh = 0;
    probe(7, 0, v); chk("R4 inhibited edge dropped", v, 0);
    ext_n = 1; repeat (4) step();
  endtask

  task automatic t_priority();
    int v;
    ext_n = 0; repeat (4) step(); ext_n = 1;
    src_req = 4'b1111; step(); src_req = 0;
    for (int s = 0; s < 4; s++) cmd(3, 3'(s));
    take_ok = 1;
    for (int s = 0; s < 5; s++) begin
      cmd(1, 0);
      @(posedge clk); #1;
      chk("R9 take pulse", int'(irq_take), 1);
      chk("R8 priority order", int'(irq_src), s);
      @(negedge clk);
      probe(7, 3'(s), v); chk("R9 winner cleared", v, 0);
      if (s < 4) begin
        probe(7, 3'(s + 1), v); chk("R9 lower still pending", v, 1);
      end
      @(posedge clk); #1;
      chk("R9 single-cycle pulse", int'(irq_take), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_defer();
    take_ok = 0;
    src_req = 4'b0010; step(); src_req = 0;
    cmd(1, 0);
    repeat (3) step();
    chk("R10 no take while take_ok low", int'(irq_take), 0);
    take_ok = 1;
    @(posedge clk); #1;
    chk("R10 take after take_ok", int'(irq_take), 1);
    chk("R10 timer index", int'(irq_src), 2);
    @(negedge clk);
    cmd(1, 0); cmd(2, 0);
    src_req = 4'b0100; step(); src_req = 0;
    repeat (3) step();
    chk("R5 master cleared blocks take", int'(irq_take), 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1; step();
    t_reset();
    t_internal();
    t_enable();
    t_ext();
    t_inhibit();
    t_priority();
    t_defer();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule